// File: doc/BRIEF.md
# Codec Register Initialization Sequencer

This block is the outer controller of a nested set of state machines that configures an audio codec after power-up. It holds a fixed list of eleven control-register writes. It hands the writes one at a time to a lower-level serial write engine, which does the byte framing on the wire. Each write is a single 16-bit word. The upper 7 bits carry the register address and the lower 9 bits carry the register value.

Each entry is passed down through a four-phase start/done handshake, and the two sides move in lockstep. The sequencer raises its request and holds it until the engine reports done. It then lowers the request and waits for done to fall before it moves to the next entry. The handshake edges alone drive progress, so the engine may take any number of cycles in any phase. After the last entry's handshake closes, a completion flag goes high and stays high until reset. Error pulses from the engine are collected into a sticky error flag.

Top module: `codec_init_seq`

## Requirements
- R1: While rst_n is low and right after it is released: xfer_start is 0, init_done is 0, init_err is 0, and xfer_word shows list entry 0.
- R2: xfer_start rises only while xfer_done is low. A done level left high from before reset keeps the first request back until done is seen low.
- R3: Once raised, xfer_start stays high until xfer_done is sampled high. It is 0 one cycle after that sample.
- R4: After a request is dropped, xfer_start stays low for as long as xfer_done stays high, however long that is.
- R5: xfer_word does not change while xfer_start or xfer_done is high.
- R6: The words are presented in list order, eleven in all, each formatted as {addr[6:0], value[8:0]}. The list, as (addr, value) in hex, is: (0F,000) (00,017) (01,017) (02,079) (03,079) (04,012) (05,000) (06,000) (07,00A) (08,000) (09,001).
- R7: One cycle after done falls on the last entry, init_done goes high. It stays high until reset, and no further request is raised.
- R8: A single-cycle pulse on xfer_err sets init_err on the next cycle, and init_err stays high until reset.
- R9: A reset in the middle of the list restarts the walk from entry 0 and clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_done | input | 1 | Done level from the lower write engine |
| xfer_err | input | 1 | Error pulse from the lower write engine |
| xfer_start | output | 1 | Request level to the lower write engine |
| xfer_word | output | 16 | Current list entry, {addr, value} |
| init_done | output | 1 | Whole list written; sticky |
| init_err | output | 1 | An engine error was seen; sticky |

## Verification
The bench plays the lower engine and uses a different latency for each entry. A sequencer that advanced on a fixed count instead of the handshake edges would skip or repeat words, and the scoreboard would catch it. The bench holds done high across reset release. A design that skipped the initial idle check would raise a request into a stale done and lose entry 0. During the closing phases the bench watches the word and the request. A design that incremented early would show the wrong word, and one that re-requested while done was still high would break the lockstep. It also resets mid-list, pulses the error input for one cycle, and checks that the completion flag neither drops nor triggers another request.

// File: rtl/codec_init_pkg.sv
// Shared types and the constant register list for the codec init sequencer.
package codec_init_pkg;

    localparam int ADDR_W = 7;
    localparam int VAL_W  = 9;
    localparam int WORD_W = ADDR_W + VAL_W;

    // Handshake controller states.
    typedef enum logic [1:0] {
        HS_ARM  = 2'd0,   // wait for done low before the first request
        HS_REQ  = 2'd1,   // request raised, wait for done high
        HS_DROP = 2'd2,   // request dropped, wait for done low
        HS_FIN  = 2'd3    // list finished, idle for good
    } hs_state_t;

    // Pack one register write into a transfer word.
    function automatic logic [WORD_W-1:0] pack_entry(input logic [ADDR_W-1:0] a,
                                                     input logic [VAL_W-1:0]  v);
        return {a, v};
    endfunction

    // Constant register list; indices past the end return zero.
    function automatic logic [WORD_W-1:0] list_entry(input int unsigned idx);
        case (idx)
            0:       return pack_entry(7'h0F, 9'h000);
            1:       return pack_entry(7'h00, 9'h017);
            2:       return pack_entry(7'h01, 9'h017);
            3:       return pack_entry(7'h02, 9'h079);
            4:       return pack_entry(7'h03, 9'h079);
            5:       return pack_entry(7'h04, 9'h012);
            6:       return pack_entry(7'h05, 9'h000);
            7:       return pack_entry(7'h06, 9'h000);
            8:       return pack_entry(7'h07, 9'h00A);
            9:       return pack_entry(7'h08, 9'h000);
            10:      return pack_entry(7'h09, 9'h001);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/init_list_rom.sv
// Constant lookup of the register list.
// Assumes: idx < N_ENTRIES; the table is built from the package function.
module init_list_rom
    import codec_init_pkg::*;
#(
    parameter int N_ENTRIES = 11,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] table_q [N_ENTRIES];

    // Build one constant table slot per list entry.
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        assign table_q[g] = list_entry(g);
    end

    // Select the slot named by the index.
    always_comb begin
        word = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (idx == IDX_W'(i)) word = table_q[i];
        end
    end

endmodule

// File: rtl/entry_counter.sv
// Index of the list entry in flight.
// Assumes: inc is never asserted while last is high.
module entry_counter #(
    parameter int N_ENTRIES = 11,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

    // Advance the index by one when the controller closes a handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)   idx <= '0;
        else if (inc) idx <= idx + 1'b1;
    end

    // Flag the final entry.
    always_comb last = (idx == LAST_IDX);

endmodule

// File: rtl/hs_ctrl.sv
// Four-phase start/done controller for the outer loop. Progress is driven only
// by the level of done; no latency of the lower engine is assumed.
module hs_ctrl
    import codec_init_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic last_i,
    output logic start_o,
    output logic advance_o,
    output logic finished_o
);

    hs_state_t state, state_nx;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= HS_ARM;
        else        state <= state_nx;
    end

    // Next-state and advance decode.
    always_comb begin
        state_nx  = state;
        advance_o = 1'b0;
        case (state)
            HS_ARM:  if (!done_i) state_nx = HS_REQ;
            HS_REQ:  if (done_i)  state_nx = HS_DROP;
            HS_DROP: if (!done_i) begin
                         if (last_i) state_nx = HS_FIN;
                         else begin
                             state_nx  = HS_REQ;
                             advance_o = 1'b1;
                         end
                     end
            default: state_nx = HS_FIN;
        endcase
    end

    // Outputs decoded from the registered state.
    always_comb begin
        start_o    = (state == HS_REQ);
        finished_o = (state == HS_FIN);
    end

endmodule

// File: rtl/codec_init_seq.sv
// Top of the codec register initialization sequencer: walks the constant list
// and hands each word to the lower write engine over a four-phase handshake.
// Assumes: the engine holds done until start falls and pulses err as needed.
module codec_init_seq
    import codec_init_pkg::*;
#(
    parameter int N_ENTRIES = 11,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_done,
    input  logic              xfer_err,
    output logic              xfer_start,
    output logic [WORD_W-1:0] xfer_word,
    output logic              init_done,
    output logic              init_err
);

    logic [IDX_W-1:0] idx;
    logic             last, advance;

    entry_counter #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(advance), .idx(idx), .last(last)
    );

    init_list_rom #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_rom (
        .idx(idx), .word(xfer_word)
    );

    hs_ctrl u_hs (
        .clk(clk), .rst_n(rst_n), .done_i(xfer_done), .last_i(last),
        .start_o(xfer_start), .advance_o(advance), .finished_o(init_done)
    );

    // Sticky collection of engine errors.
    always_ff @(posedge clk) begin
        if (!rst_n)        init_err <= 1'b0;
        else if (xfer_err) init_err <= 1'b1;
    end

endmodule

// File: rtl/codec_init_chk.sv
// Protocol checker for codec_init_seq, attached by bind.
module codec_init_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        xfer_done,
    input logic        xfer_err,
    input logic        xfer_start,
    input logic [15:0] xfer_word,
    input logic        init_done,
    input logic        init_err
);

    a_r3_hold_start: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start && !xfer_done |=> xfer_start);

    a_r3_drop_start: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start && xfer_done |=> !xfer_start);

    a_r4_no_rerequest: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_start && xfer_done |=> !xfer_start);

    a_r5_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start || xfer_done) |=> $stable(xfer_word));

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r7_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !xfer_start);

    a_r8_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |=> init_err);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |=> init_err);

endmodule

bind codec_init_seq codec_init_chk u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .xfer_start(xfer_start), .xfer_word(xfer_word),
    .init_done(init_done), .init_err(init_err)
);

// File: tb/sim_codec_init_seq.sv
// Scoreboard bench: the driver pushes expected words, a monitor pops them at
// each new request, and the main flow plays the lower write engine.
module sim_codec_init_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_done = 1'b0;
    logic        xfer_err = 1'b0;
    logic        xfer_start;
    logic [15:0] xfer_word;
    logic        init_done;
    logic        init_err;

    int checks = 0;
    int fails  = 0;
    int seen   = 0;
    bit ended  = 1'b0;
    logic [15:0] exp_q[$];
    logic [15:0] tbl[11];

    always #5 clk = ~clk;

    codec_init_seq u0 (
        .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .xfer_err(xfer_err),
        .xfer_start(xfer_start), .xfer_word(xfer_word),
        .init_done(init_done), .init_err(init_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: queue the expected list in order (R6).
    task automatic push_list();
        exp_q.delete();
        for (int i = 0; i < 11; i++) exp_q.push_back(tbl[i]);
    endtask

    // Monitor: pop and compare on each new request (R6, R9).
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && xfer_start && !prev) begin
                seen++;
                if (exp_q.size() == 0) check("R6 extra request", 32'(xfer_word), 32'hFFFF);
                else check("R6 word order", 32'(xfer_word), 32'(exp_q.pop_front()));
            end
            prev = rst_n && xfer_start;
        end
    end

    // Play the lower engine for one entry with the given latency.
    task automatic serve(input int i, input int lat, input bit pulse_err);
        int w = 0;
        while (!xfer_start && w < 200) begin @(negedge clk); w++; end
        check("R3 request seen", 32'(xfer_start), 32'd1);
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            check("R3 start held", 32'(xfer_start), 32'd1);
        end
        xfer_done = 1'b1;
        @(negedge clk);
        check("R3 start dropped", 32'(xfer_start), 32'd0);
        for (int k = 0; k < lat; k++) begin
            if (pulse_err && k == 0) xfer_err = 1'b1;
            @(negedge clk);
            xfer_err = 1'b0;
            check("R4 no re-request", 32'(xfer_start), 32'd0);
            check("R5 word stable", 32'(xfer_word), 32'(tbl[i]));
            if (pulse_err && k == 0) check("R8 err set", 32'(init_err), 32'd1);
        end
        xfer_done = 1'b0;
    endtask

    // Watchdog.
    initial begin
        #1500000;
        if (!ended) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 11; i++) tbl[i] = codec_entry(i);
        // R1: reset state with a stale done held high.
        xfer_done = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 start in reset", 32'(xfer_start), 32'd0);
        check("R1 done flag in reset", 32'(init_done), 32'd0);
        check("R1 err flag in reset", 32'(init_err), 32'd0);
        check("R1 entry 0 shown", 32'(xfer_word), 32'(tbl[0]));
        rst_n = 1'b1;
        // R2: no request while stale done stays high.
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R2 held off by stale done", 32'(xfer_start), 32'd0);
        end
        push_list();
        xfer_done = 1'b0;
        // R9: walk three entries, then reset mid-list.
        for (int i = 0; i < 3; i++) serve(i, i + 1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 start after mid reset", 32'(xfer_start), 32'd0);
        check("R9 word back to entry 0", 32'(xfer_word), 32'(tbl[0]));
        push_list();
        seen = 0;
        rst_n = 1'b1;
        // Full walk with varying latency and an error pulse on entry 5.
        for (int i = 0; i < 11; i++) serve(i, (i * 3) % 5 + 1, i == 5);
        @(negedge clk);
        check("R7 finished flag", 32'(init_done), 32'd1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check("R7 stays finished", 32'(init_done), 32'd1);
            check("R7 no more requests", 32'(xfer_start), 32'd0);
        end
        check("R8 err sticky", 32'(init_err), 32'd1);
        check("R6 all entries seen", 32'(seen), 32'd11);
        check("R6 queue drained", 32'(exp_q.size()), 32'd0);
        // R9: reset clears both flags.
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 done cleared", 32'(init_done), 32'd0);
        check("R9 err cleared", 32'(init_err), 32'd0);
        ended = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Bench's own copy of the list from R6: {addr, value}.
    function automatic logic [15:0] codec_entry(input int i);
        logic [6:0] a [11] = '{7'h0F, 7'h00, 7'h01, 7'h02, 7'h03, 7'h04,
                               7'h05, 7'h06, 7'h07, 7'h08, 7'h09};
        logic [8:0] v [11] = '{9'h000, 9'h017, 9'h017, 9'h079, 9'h079, 9'h012,
                               9'h000, 9'h000, 9'h00A, 9'h000, 9'h001};
        return {a[i], v[i]};
    endfunction

endmodule